// File: doc/BRIEF.md
# Delay-Slot Next-PC Sequencer

This block chooses the next fetch address of a five-stage in-order pipeline (stages P0 to P4). P0 holds the fetch address, the decoder works in P2, and the flags that decide a conditional transfer settle once the instruction ahead of the transfer has reached P4. By then the transfer itself sits in P3. Three instructions behind a transfer have already entered the pipe when the new address is selected.

The programmer encodes 0 to 3 delay slots in each jump, call or return. A Mealy state machine follows a separate state path for each slot count. The requested number of following instructions go on to execute. For the remaining ones, a squash output makes the decoder see a no-operation in their place. The next address comes from one of three sources: the incremented PC, a target latched when the decoder flagged the transfer, or the top of a small return-address stack. Calls push onto that stack and returns pop from it.

Top module: `pc_seq`

## Requirements
- R1: While `rst_i` is high and in the first cycle after it falls, `pc_o` equals RESET_PC (default 0), `nop_o` is low and `pc_sel_o` reads 0. The `pc_sel_o` encoding is 0 for increment, 1 for latched target and 2 for stack top.
- R2: With no transfer accepted, `pc_o` rises by one every cycle and no decoded instruction is squashed.
- R3: A taken transfer with slot count n (from `slots_i`) lets the n instructions after it execute. `nop_o` is high while each of the remaining 3-n instructions is in decode. The new address is in `pc_o` two cycles after the strobe.
- R4: `take_i` is sampled once, one cycle after the jump strobe, while the jump is in P3. If it is low, nothing is squashed and fetch continues sequentially.
- R5: The jump target on `tgt_i` is latched in the cycle the strobe is accepted, and that latched value is what reaches `pc_o`.
- R6: A taken call (`jmp_i` and `call_i` high) pushes the address that follows its executed delay slots. A return restores the most recently pushed address and removes it. Nesting up to STK_DEPTH levels is kept.
- R7: A return is always taken, and `take_i` has no effect on it.
- R8: If `ret_i` and `jmp_i` are high together, the instruction acts as a return.
- R9: Strobes are ignored from the cycle after acceptance until the sequencer is idle again. This covers strobes from executed delay slots and from the instruction right after a not-taken jump.
- R10: `nop_o` is only ever high during one of the three cycles that follow an accepted transfer. It is never high while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| jmp_i | input | 1 | Jump or call decoded in P2 |
| call_i | input | 1 | Qualifies `jmp_i` as a call that saves a return address |
| ret_i | input | 1 | Return decoded in P2 |
| slots_i | input | 2 | Number of delay slots to execute (0..3) |
| take_i | input | 1 | Jump decision, valid while the jump is in P3 |
| tgt_i | input | AW | Jump or call target, valid with the strobe |
| pc_o | output | AW | Fetch address (P0) |
| nop_o | output | 1 | Replace the instruction now in decode with a no-operation |
| pc_sel_o | output | 2 | Next-address source select |

## Verification
The bench models a program memory and the pipeline stages around the block, and compares the executed address stream with an instruction-level reference model. Directed programs cover a straight-line run, a taken jump at each of the four slot counts, and a not-taken jump that has a transfer right behind it. Another directed program places a transfer inside an executed delay slot. A nested call/return program mixes conditional calls, a return with its decision bit cleared, and a combined jump-and-return encoding. Seeded random programs made of jumps with random slot counts, decisions and targets then exercise back-to-back and overlapping transfers. Any error in squash counting, decision timing or target selection shifts the executed sequence.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int SLOT_W = 2;

  typedef enum logic [1:0] {
    SRC_INC = 2'd0,
    SRC_JMP = 2'd1,
    SRC_RET = 2'd2
  } pc_src_e;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_W0   = 4'd1,  ST_W1  = 4'd2,  ST_W2  = 4'd3,  ST_W3  = 4'd4,
    ST_A0   = 4'd5,  ST_A1  = 4'd6,  ST_A2  = 4'd7,  ST_A3  = 4'd8,
    ST_B0   = 4'd9,  ST_B1  = 4'd10, ST_B2  = 4'd11, ST_B3  = 4'd12
  } seq_st_e;

  function automatic seq_st_e wait_st(input logic [SLOT_W-1:0] n);
    case (n)
      2'd0:    return ST_W0;
      2'd1:    return ST_W1;
      2'd2:    return ST_W2;
      default: return ST_W3;
    endcase
  endfunction

  function automatic seq_st_e a_st(input logic [SLOT_W-1:0] n);
    case (n)
      2'd0:    return ST_A0;
      2'd1:    return ST_A1;
      2'd2:    return ST_A2;
      default: return ST_A3;
    endcase
  endfunction

  function automatic seq_st_e b_st(input logic [SLOT_W-1:0] n);
    case (n)
      2'd0:    return ST_B0;
      2'd1:    return ST_B1;
      2'd2:    return ST_B2;
      default: return ST_B3;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] st_slots(input seq_st_e s);
    case (s)
      ST_W1, ST_A1, ST_B1: return 2'd1;
      ST_W2, ST_A2, ST_B2: return 2'd2;
      ST_W3, ST_A3, ST_B3: return 2'd3;
      default:             return 2'd0;
    endcase
  endfunction

  function automatic logic is_wait(input seq_st_e s);
    return (s == ST_W0) || (s == ST_W1) || (s == ST_W2) || (s == ST_W3);
  endfunction

endpackage

// File: rtl/pcs_fsm.sv
module pcs_fsm
  import pcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              jmp_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [SLOT_W-1:0] slots_i,
  input  logic              take_i,
  output logic              cap_o,
  output logic              nop_o,
  output pc_src_e           src_o,
  output logic              push_o,
  output logic              pop_o,
  output logic [SLOT_W-1:0] slots_o
);

  seq_st_e st_q, st_d;
  logic    ret_q, call_q;
  logic    accept, eff_take;
  logic [SLOT_W-1:0] n;

  assign accept   = (st_q == ST_IDLE) && (jmp_i || ret_i);
  assign n        = st_slots(st_q);
  assign eff_take = ret_q || take_i;
  assign cap_o    = accept;
  assign slots_o  = n;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q   <= ST_IDLE;
      ret_q  <= 1'b0;
      call_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        ret_q  <= ret_i;
        call_q <= call_i && !ret_i;
      end
    end
  end

  always_comb begin
    st_d   = st_q;
    nop_o  = 1'b0;
    src_o  = SRC_INC;
    push_o = 1'b0;
    pop_o  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) st_d = wait_st(slots_i);
      end
      ST_W0, ST_W1, ST_W2, ST_W3: begin
        if (eff_take) begin
          src_o  = ret_q ? SRC_RET : SRC_JMP;
          pop_o  = ret_q;
          push_o = call_q;
          nop_o  = (n == 2'd0);
          st_d   = a_st(n);
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_A0, ST_A1, ST_A2, ST_A3: begin
        nop_o = (n < 2'd2);
        st_d  = b_st(n);
      end
      ST_B0, ST_B1, ST_B2, ST_B3: begin
        nop_o = (n < 2'd3);
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // R10
  nop_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == ST_IDLE) |-> !nop_o);

  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((st_q != ST_IDLE) && (jmp_i || ret_i)) |=> !is_wait(st_q));

  // R4
  decide_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (is_wait(st_q) && !ret_q && !take_i) |=> (st_q == ST_IDLE));

  // R3
  walk_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (is_wait(st_q) && eff_take) |=> ($past(n) == st_slots(st_q)) && (st_q != ST_IDLE));

endmodule

// File: rtl/pcs_retstack.sv
module pcs_retstack #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o
);

  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] sp_q;
  logic [IW-1:0] wr_idx, rd_idx;
  logic          full, empty;

  assign full   = (sp_q == PW'(DEPTH));
  assign empty  = (sp_q == '0);
  assign wr_idx = IW'(sp_q);
  assign rd_idx = IW'(sp_q - 1'b1);

  always_ff @(posedge clk_i) begin
    if (push_i && !full) mem[wr_idx] <= data_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) sp_q <= '0;
    else if (pop_i && !empty) sp_q <= sp_q - 1'b1;
    else if (push_i && !full) sp_q <= sp_q + 1'b1;
  end

  assign top_o = empty ? '0 : mem[rd_idx];

  // R6
  sp_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    sp_q <= PW'(DEPTH));

  // R6
  push_grow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (push_i && !pop_i && !full) |=> (sp_q == $past(sp_q) + 1'b1) && (top_o == $past(data_i)));

endmodule

// File: rtl/pcs_pcreg.sv
module pcs_pcreg
  import pcs_pkg::*;
#(
  parameter int          AW       = 8,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          cap_i,
  input  logic [AW-1:0] tgt_i,
  input  pc_src_e       src_i,
  input  logic [AW-1:0] stk_i,
  output logic [AW-1:0] pc_o
);

  logic [AW-1:0] pc_q, tgt_q, pc_d;

  always_ff @(posedge clk_i) begin
    if (rst_i) tgt_q <= '0;
    else if (cap_i) tgt_q <= tgt_i;
  end

  always_comb begin
    case (src_i)
      SRC_JMP: pc_d = tgt_q;
      SRC_RET: pc_d = stk_i;
      default: pc_d = pc_q + 1'b1;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) pc_q <= RESET_PC;
    else       pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R1
  rst_pc_chk: assert property (@(posedge clk_i)
    rst_i |=> (pc_q == RESET_PC));

  // R2
  inc_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (src_i == SRC_INC) |=> (pc_q == $past(pc_q) + 1'b1));

  // R5
  jmp_tgt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cap_i && src_i == SRC_INC) |=> (tgt_q == $past(tgt_i)));

endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pcs_pkg::*;
#(
  parameter int            AW        = 8,
  parameter int            STK_DEPTH = 4,
  parameter logic [AW-1:0] RESET_PC  = '0
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          jmp_i,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic [1:0]    slots_i,
  input  logic          take_i,
  input  logic [AW-1:0] tgt_i,
  output logic [AW-1:0] pc_o,
  output logic          nop_o,
  output logic [1:0]    pc_sel_o
);

  localparam logic [AW-1:0] BACK_OFS = AW'(2);

  pc_src_e           src;
  logic              cap, push, pop;
  logic [SLOT_W-1:0] cur_slots;
  logic [AW-1:0]     stk_top, ret_addr, pc;

  pcs_fsm i_fsm (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .jmp_i   (jmp_i),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .slots_i (slots_i),
    .take_i  (take_i),
    .cap_o   (cap),
    .nop_o   (nop_o),
    .src_o   (src),
    .push_o  (push),
    .pop_o   (pop),
    .slots_o (cur_slots)
  );

  // The call sits in P3 while the PC already points three past it.
  assign ret_addr = pc + AW'(cur_slots) - BACK_OFS;

  pcs_retstack #(.DEPTH(STK_DEPTH), .W(AW)) i_stack (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .push_i (push),
    .pop_i  (pop),
    .data_i (ret_addr),
    .top_o  (stk_top)
  );

  pcs_pcreg #(.AW(AW), .RESET_PC(RESET_PC)) i_pcreg (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .cap_i (cap),
    .tgt_i (tgt_i),
    .src_i (src),
    .stk_i (stk_top),
    .pc_o  (pc)
  );

  assign pc_o     = pc;
  assign pc_sel_o = src;

  // R6
  ret_target_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (pop && push == 1'b0) |=> (pc_o == $past(stk_top)));

endmodule

// File: tb/test_pc_seq.sv
module test_pc_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int MAXLOG = 256;

  typedef struct packed {
    logic       j;
    logic       c;
    logic       r;
    logic       tk;
    logic [1:0] n;
    logic [7:0] t;
  } ins_t;

  logic clk = 1'b0, rst = 1'b1;
  logic jmp = 0, call = 0, ret = 0, take = 0;
  logic [1:0] slots = 0;
  logic [AW-1:0] tgt = 0, pc;
  logic nop;
  logic [1:0] sel;

  ins_t prog [64];
  logic [7:0] got_a [MAXLOG];
  logic [7:0] exp_a [MAXLOG];
  int nlog;
  int n_chk = 0, n_bad = 0;
  logic [7:0] p0, p1, p2, p3;
  logic v0, v1, v2, v3;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_seq i_pc_seq (
    .clk_i (clk), .rst_i (rst), .jmp_i (jmp), .call_i (call), .ret_i (ret),
    .slots_i (slots), .take_i (take), .tgt_i (tgt),
    .pc_o (pc), .nop_o (nop), .pc_sel_o (sel)
  );

  task automatic check(input string tag, input int got, input int expv);
    n_chk++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  function automatic ins_t norm();
    return '0;
  endfunction

  function automatic ins_t mk(input logic j, input logic c, input logic r,
                              input logic tk, input logic [1:0] n, input logic [7:0] t);
    ins_t x;
    x.j = j; x.c = c; x.r = r; x.tk = tk; x.n = n; x.t = t;
    return x;
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = norm();
  endtask

  // Instruction-level reference of the executed address stream
  task automatic build_ref(input int m);
    logic [7:0] a, dest;
    logic [7:0] stk [8];
    int sp, k;
    ins_t in;
    logic tk;
    a = 0; sp = 0; k = 0;
    while (k < m) begin
      in = prog[a[5:0]];
      exp_a[k] = a; k++;
      if (in.j || in.r) begin
        tk = in.r ? 1'b1 : in.tk;
        if (tk) begin
          for (int i = 1; i <= int'(in.n); i++)
            if (k < m) begin exp_a[k] = a + 8'(i); k++; end
          if (in.r) begin
            if (sp > 0) sp--;
            dest = stk[sp];
          end else begin
            dest = in.t;
            if (in.c && sp < 8) begin stk[sp] = a + 8'(in.n) + 8'd1; sp++; end
          end
          a = dest;
        end else begin
          if (k < m) begin exp_a[k] = a + 8'd1; k++; end
          a = a + 8'd2;
        end
      end else begin
        a = a + 8'd1;
      end
    end
  endtask

  task automatic step();
    ins_t in;
    p3 = p2; v3 = v2;
    p2 = p1; v2 = v1;
    p1 = p0; v1 = v0;
    p0 = pc; v0 = 1'b1;
    take = v3 ? prog[p3[5:0]].tk : 1'b0;
    #1;
    if (v2 && !nop) begin
      in = prog[p2[5:0]];
      if (nlog < MAXLOG) begin got_a[nlog] = p2; nlog++; end
      jmp = in.j; call = in.c; ret = in.r; slots = in.n; tgt = in.t;
    end else begin
      jmp = 0; call = 0; ret = 0; slots = 0; tgt = 0;
    end
  endtask

  task automatic run_prog(input string tag, input int cycles);
    rst = 1'b1;
    jmp = 0; call = 0; ret = 0; slots = 0; take = 0; tgt = 0;
    v0 = 0; v1 = 0; v2 = 0; v3 = 0;
    p0 = 0; p1 = 0; p2 = 0; p3 = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nlog = 0;
    step();
    repeat (cycles - 1) begin
      @(negedge clk);
      step();
    end
    @(negedge clk);
    jmp = 0; call = 0; ret = 0;
    build_ref(nlog);
    check({tag, " executed-count"}, int'(nlog > cycles / 3), 1);
    for (int i = 0; i < nlog; i++) check(tag, int'(got_a[i]), int'(exp_a[i]));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);

    // R1: reset state, with a strobe present during reset
    clear_prog();
    rst = 1'b1; jmp = 1'b1; tgt = 8'd33; take = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pc", int'(pc), 0);
    check("R1 nop", int'(nop), 0);
    check("R1 sel", int'(sel), 0);
    jmp = 1'b0; take = 1'b0;
    rst = 1'b0;
    #1;
    check("R1 pc after release", int'(pc), 0);
    check("R1 nop after release", int'(nop), 0);
    check("R1 sel after release", int'(sel), 0);
    @(negedge clk);
    check("R1 first increment", int'(pc), 1);

    // R2 R10: straight line code, nothing squashed
    clear_prog();
    run_prog("R2 R10 sequential", 40);

    // R3: taken jump with each slot count
    for (int n = 0; n < 4; n++) begin
      clear_prog();
      prog[5]  = mk(1, 0, 0, 1, 2'(n), 8'd20);
      prog[25] = mk(1, 0, 0, 1, 2'd3, 8'd0);
      run_prog($sformatf("R3 slots=%0d", n), 60);
    end

    // R4 R9: not-taken jump followed by a transfer that is ignored
    clear_prog();
    prog[5]  = mk(1, 0, 0, 0, 2'd1, 8'd20);
    prog[6]  = mk(1, 0, 0, 1, 2'd0, 8'd30);
    prog[7]  = mk(1, 0, 0, 0, 2'd2, 8'd40);
    prog[12] = mk(1, 0, 0, 1, 2'd0, 8'd0);
    run_prog("R4 R9 not-taken", 50);

    // R9 R3: transfer inside an executed delay slot is ignored
    clear_prog();
    prog[5]  = mk(1, 0, 0, 1, 2'd3, 8'd20);
    prog[6]  = mk(1, 0, 0, 1, 2'd0, 8'd40);
    prog[7]  = mk(0, 0, 1, 1, 2'd0, 8'd0);
    prog[24] = mk(1, 0, 0, 1, 2'd1, 8'd0);
    run_prog("R9 R3 slot-transfer", 50);

    // R6 R7 R8: nested call/return, conditional call not taken
    clear_prog();
    prog[2]  = mk(1, 1, 0, 1, 2'd1, 8'd20);
    prog[8]  = mk(1, 1, 0, 0, 2'd0, 8'd60);
    prog[12] = mk(1, 0, 0, 1, 2'd0, 8'd0);
    prog[21] = mk(1, 1, 0, 1, 2'd2, 8'd40);
    prog[24] = mk(1, 0, 1, 0, 2'd3, 8'd50);
    prog[41] = mk(0, 0, 1, 0, 2'd0, 8'd0);
    run_prog("R6 R7 R8 call-return", 120);

    // R3 R4 R5: seeded random jump programs
    for (int s = 0; s < 6; s++) begin
      clear_prog();
      for (int i = 0; i < 64; i++) begin
        if (($urandom % 4) == 0)
          prog[i] = mk(1, 0, 0, 1'($urandom % 2), 2'($urandom % 4), 8'($urandom % 64));
      end
      run_prog($sformatf("R3 R4 R5 random#%0d", s), 150);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule